// File: doc/BRIEF.md
# Exclusive access reservation monitor

This block keeps a single load-exclusive reservation for one core and decides whether the matching store-exclusive may write memory. An exclusive load with an aligned address records the address and the access size, and marks the reservation live. A later exclusive store is allowed to write only if that reservation is still live and the store repeats the load's address and size exactly. The block reports the decision in the same cycle as the store request. It raises a store-permit line that the memory path uses to commit or drop the write, and it returns a one-bit status: 0 means the store succeeded and 1 means it failed.

Three events end a reservation. The first is any exclusive store, whether it succeeds or fails. The second is an explicit clear command, which is used on interrupt entry or a context switch. The third is a write by another agent that lands anywhere in the same reservation granule. The granule size is a parameter and can be up to 2 KB. Every case the usage rules leave undefined is given a fixed result here. A misaligned access, or a store whose address or size differs from the load, always fails and never writes.

Top module: `xmon`

## Requirements
- R1: When `ld_valid` is high with an aligned address and a legal size code, the block records `ld_addr` and `ld_size` at the next rising edge and marks the reservation live. A matching store issued later then succeeds.
- R2: While `st_valid` is high, the outputs are combinational in the same cycle. `st_permit`=1 and `st_status`=0 only when the reservation is live and the store matches it. Otherwise `st_permit`=0 and `st_status`=1. While `st_valid` is low, both outputs are 0.
- R3: Every exclusive store, whether it succeeds or fails, ends the reservation at the next edge, so a repeated identical store fails.
- R4: `clr` ends the reservation at the next edge. A store presented in the same cycle as `clr` fails.
- R5: A snoop write to an address whose bits above log2(`GRANULE_BYTES`) equal those of the reserved address ends the reservation. A snoop write to any other granule has no effect.
- R6: The size codes are 0=byte (1 B), 1=halfword (2 B), 2=word (4 B), 3=doubleword (8 B), 4=pair of words (8 B) and 5=pair of doublewords (16 B). Codes 6 and 7 are illegal. `align_err` is high in the same cycle whenever a valid load or store has an illegal size code or an address that is not a multiple of its byte count.
- R7: A misaligned or illegal exclusive store fails. A misaligned or illegal exclusive load creates no reservation and discards any existing one.
- R8: A store whose address or size code differs from the reserving load fails. Pair-of-words (code 4) followed by doubleword (code 3) counts as a size mismatch.
- R9: A new exclusive load replaces any earlier reservation. If a load and a store or clear arrive in the same cycle, the load's reservation is the one kept.
- R10: When a snoop write to the reserved granule arrives in the same cycle as a matching store, the store fails.
- R11: Reset (`rst_n` low) clears the reservation, so the first store after reset fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Exclusive load request |
| ld_addr | input | AW | Exclusive load byte address |
| ld_size | input | 3 | Exclusive load size code |
| st_valid | input | 1 | Exclusive store request |
| st_addr | input | AW | Exclusive store byte address |
| st_size | input | 3 | Exclusive store size code |
| clr | input | 1 | Discard reservation command |
| snoop_valid | input | 1 | Write by another agent observed |
| snoop_addr | input | AW | Address of that write |
| st_permit | output | 1 | Commit the exclusive store |
| st_status | output | 1 | Store result, 0 success, 1 failure |
| align_err | output | 1 | Misaligned or illegal-size exclusive access |

## Verification
The main function is exercised with several store patterns:
- a load followed by an exact match;
- mismatches in address alone and in size alone, including the pair-versus-doubleword case, which separates comparing sizes from comparing byte counts;
- snoops at the far edge of the reserved granule and just past it, which pin down the granule boundary;
- same-cycle collisions of a store with a snoop and with a clear, which fix the priority;
- back-to-back stores, which show that even a failed store consumes the reservation;
- reloads to a new address, which show the old address is forgotten.

// File: rtl/xmon.sv
module xmon #(
  parameter int AW = 32,
  parameter int GRANULE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [2:0]    ld_size,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [2:0]    st_size,
  input  logic          clr,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  output logic          st_permit,
  output logic          st_status,
  output logic          align_err
);
  localparam int GL = $clog2(GRANULE_BYTES);

  logic          res_valid;
  logic [AW-1:0] res_addr;
  logic [2:0]    res_size;

  function automatic logic aligned(input logic [AW-1:0] a, input logic [2:0] sz);
    logic [3:0] m;
    logic legal;
    legal = 1'b1;
    case (sz)
      3'd0: m = 4'h0;
      3'd1: m = 4'h1;
      3'd2: m = 4'h3;
      3'd3, 3'd4: m = 4'h7;
      3'd5: m = 4'hF;
      default: begin m = 4'h0; legal = 1'b0; end
    endcase
    return legal && ((a[3:0] & m) == 4'h0);
  endfunction

  logic ld_ok, st_ok, snoop_kill, live, same;

  assign ld_ok      = aligned(ld_addr, ld_size);
  assign st_ok      = aligned(st_addr, st_size);
  assign snoop_kill = snoop_valid && res_valid && (snoop_addr[AW-1:GL] == res_addr[AW-1:GL]);
  assign live       = res_valid && !clr && !snoop_kill;
  assign same       = (st_addr == res_addr) && (st_size == res_size);

  assign st_permit = st_valid && st_ok && live && same;
  assign st_status = st_valid && !st_permit;
  assign align_err = (ld_valid && !ld_ok) || (st_valid && !st_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_size  <= '0;
    end else if (ld_valid) begin
      res_valid <= ld_ok;
      res_addr  <= ld_addr;
      res_size  <= ld_size;
    end else if (st_valid || clr || snoop_kill) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xmon_props.sv
module xmon_props #(
  parameter int AW = 32,
  parameter int GRANULE_BYTES = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic          st_valid,
  input logic [AW-1:0] st_addr,
  input logic          clr,
  input logic          snoop_valid,
  input logic [AW-1:0] snoop_addr,
  input logic          st_permit,
  input logic          st_status,
  input logic          align_err
);
  localparam int GL = $clog2(GRANULE_BYTES);

  p_permit_needs_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_permit |-> (st_valid && !st_status));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |-> (!st_permit && !st_status));

  p_store_consumes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !ld_valid) |=> !st_permit);

  p_clear_consumes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ld_valid) |=> !st_permit);

  p_clear_same_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !st_permit);

  p_misaligned_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !ld_valid && align_err) |-> !st_permit);

  p_snoop_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && snoop_valid && (snoop_addr[AW-1:GL] == st_addr[AW-1:GL])) |-> !st_permit);
endmodule

bind xmon xmon_props #(.AW(AW), .GRANULE_BYTES(GRANULE_BYTES)) u_props (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .st_valid(st_valid),
  .st_addr(st_addr), .clr(clr), .snoop_valid(snoop_valid),
  .snoop_addr(snoop_addr), .st_permit(st_permit), .st_status(st_status),
  .align_err(align_err)
);

// File: tb/xmon_test.sv
module xmon_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, st_valid = 1'b0, clr = 1'b0, snoop_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0, st_addr = '0, snoop_addr = '0;
  logic [2:0] ld_size = '0, st_size = '0;
  logic st_permit, st_status, align_err;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xmon #(.AW(AW), .GRANULE_BYTES(64)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size), .clr(clr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .st_permit(st_permit), .st_status(st_status), .align_err(align_err)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic idle();
    ld_valid = 0; st_valid = 0; clr = 0; snoop_valid = 0;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [2:0] s);
    @(negedge clk); idle(); ld_valid = 1; ld_addr = a; ld_size = s;
    @(negedge clk); idle();
  endtask

  task automatic store(input string req, input logic [AW-1:0] a, input logic [2:0] s,
                       input logic exp_ok, input logic do_clr, input logic do_snoop,
                       input logic [AW-1:0] sa);
    @(negedge clk); idle();
    st_valid = 1; st_addr = a; st_size = s; clr = do_clr;
    snoop_valid = do_snoop; snoop_addr = sa;
    #3;
    chk(req, "st_permit", st_permit, exp_ok);
    chk(req, "st_status", st_status, !exp_ok);
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    #3;
    chk("R11", "permit idle in reset", st_permit, 1'b0);
    chk("R2", "status idle", st_status, 1'b0);
    chk("R6", "align_err idle", align_err, 1'b0);
    @(negedge clk); rst_n = 1;
    store("R11", 32'h100, 3'd2, 1'b0, 0, 0, 0);
  endtask

  task automatic t_basic();
    load(32'h1000, 3'd2);
    store("R1", 32'h1000, 3'd2, 1'b1, 0, 0, 0);
    store("R3", 32'h1000, 3'd2, 1'b0, 0, 0, 0);
    load(32'h1010, 3'd3);
    store("R8", 32'h1018, 3'd3, 1'b0, 0, 0, 0);
    store("R3", 32'h1010, 3'd3, 1'b0, 0, 0, 0);
    load(32'h2000, 3'd4);
    store("R8", 32'h2000, 3'd3, 1'b0, 0, 0, 0);
    load(32'h2000, 3'd4);
    store("R1", 32'h2000, 3'd4, 1'b1, 0, 0, 0);
  endtask

  task automatic t_clear();
    load(32'h3000, 3'd1);
    @(negedge clk); clr = 1; @(negedge clk); idle();
    store("R4", 32'h3000, 3'd1, 1'b0, 0, 0, 0);
    load(32'h3000, 3'd1);
    store("R4", 32'h3000, 3'd1, 1'b0, 1, 0, 0);
  endtask

  task automatic t_snoop();
    load(32'h4000, 3'd0);
    @(negedge clk); snoop_valid = 1; snoop_addr = 32'h4040; @(negedge clk); idle();
    store("R5", 32'h4000, 3'd0, 1'b1, 0, 0, 0);
    load(32'h4000, 3'd0);
    @(negedge clk); snoop_valid = 1; snoop_addr = 32'h403F; @(negedge clk); idle();
    store("R5", 32'h4000, 3'd0, 1'b0, 0, 0, 0);
    load(32'h4000, 3'd0);
    store("R10", 32'h4000, 3'd0, 1'b0, 0, 1, 32'h4020);
  endtask

  task automatic t_align();
    @(negedge clk); ld_valid = 1; ld_addr = 32'h5002; ld_size = 3'd2; #3;
    chk("R6", "align_err misaligned load", align_err, 1'b1);
    @(negedge clk); ld_size = 3'd6; #3;
    chk("R6", "align_err illegal code", align_err, 1'b1);
    @(negedge clk); ld_addr = 32'h5008; ld_size = 3'd5; #3;
    chk("R6", "align_err pair16 at 8", align_err, 1'b1);
    @(negedge clk); ld_addr = 32'h5010; #3;
    chk("R6", "align_err pair16 at 16", align_err, 1'b0);
    @(negedge clk); idle();
    load(32'h5004, 3'd2);
    load(32'h5006, 3'd2);
    store("R7", 32'h5004, 3'd2, 1'b0, 0, 0, 0);
    load(32'h5006, 3'd2);
    @(negedge clk); st_valid = 1; st_addr = 32'h5006; st_size = 3'd2; #3;
    chk("R7", "align_err misaligned store", align_err, 1'b1);
    chk("R7", "misaligned store permit", st_permit, 1'b0);
    @(negedge clk); idle();
  endtask

  task automatic t_replace();
    load(32'h6000, 3'd3);
    load(32'h7000, 3'd3);
    store("R9", 32'h6000, 3'd3, 1'b0, 0, 0, 0);
    load(32'h6000, 3'd3);
    load(32'h7000, 3'd3);
    store("R9", 32'h7000, 3'd3, 1'b1, 0, 0, 0);
    @(negedge clk); ld_valid = 1; ld_addr = 32'h8000; ld_size = 3'd2; clr = 1;
    @(negedge clk); idle();
    store("R9", 32'h8000, 3'd2, 1'b1, 0, 0, 0);
  endtask

  task automatic t_reset_mid();
    load(32'h9000, 3'd2);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    store("R11", 32'h9000, 3'd2, 1'b0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_basic(); t_clear(); t_snoop(); t_align(); t_replace(); t_reset_mid();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          errors++; vectors++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule